// File: doc/BRIEF.md
# USB Host Interrupt Status Aggregator

This block gathers the interrupt causes of a frame-scheduled USB host controller into one level-sensitive interrupt line. Causes come from two places. The first is the transaction engine, which reports three kinds of per-transaction event: a completion whose descriptor asked for an interrupt, a transaction error, and a short packet. The second is the controller's host-memory access path, which reports access errors. The block keeps one sticky status bit per cause, and software clears these bits by writing ones.

Transaction causes are not shown the moment they happen. Each event is first latched as pending. Pending events become visible status only at the first status-writeback-done strobe that comes after an end-of-frame strobe. By the time the interrupt can fire, the status of the frame's last completed transaction is therefore already in memory, and software can safely walk descriptors up to one less than the current frame-list index. Access errors skip this gating and also skip the software enable mask. The interrupt output is registered and stays high until every contributing status bit has been cleared.

Top module: `usbirq_agg`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `status_o` reads all zeros and `irq_o` is low.
- R2: A transaction event (`txn_ev_i` bit 0 = completion with interrupt request, bit 1 = error, bit 2 = short packet) does not change `status_o` bits 0..2 until it is released. Before release it is held as pending.
- R3: Release happens on the first cycle with `wb_done_i` high that follows a cycle with `eof_i` high. A `wb_done_i` in the same cycle as `eof_i`, or with no earlier `eof_i`, releases nothing. On release, every pending event is ORed into `status_o` bits 0..2, visible one cycle later, and the pending set is emptied. An `eof_i` in the release cycle arms the next release.
- R4: A transaction event that arrives in a release cycle is not released in that cycle. It stays pending for the next release.
- R5: A high bit j of `acc_err_i` sets `status_o` bit 3+j one cycle later, whatever the enable mask holds.
- R6: When `clr_we_i` is high, each status bit whose `clr_data_i` bit is 1 reads 0 on the next cycle. Bits written with 0 keep their value.
- R7: If a set and a write-one clear hit the same status bit in the same cycle, the bit reads 1 afterwards.
- R8: `irq_o` equals, one cycle late, the OR of (`status_o` bits 0..2 AND `irq_en_i` bits 0..2) with all access-error status bits. `irq_en_i` uses the same bit order as the transaction causes.
- R9: A transaction status bit whose enable bit is 0 stays visible in `status_o` but does not raise `irq_o`. `irq_o` stays high until every contributing bit is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txn_ev_i | input | 3 | Per-transaction event pulses: [0] completion with interrupt request, [1] error, [2] short packet |
| eof_i | input | 1 | End-of-frame strobe |
| wb_done_i | input | 1 | Status-writeback-done strobe |
| acc_err_i | input | ACC_W | Host-memory access error pulses |
| irq_en_i | input | 3 | Software enable mask for transaction causes |
| clr_we_i | input | 1 | Write strobe for write-one-to-clear |
| clr_data_i | input | 3+ACC_W | Bits to clear |
| status_o | output | 3+ACC_W | Visible sticky status: [2:0] transaction causes, [3+] access errors |
| irq_o | output | 1 | Registered level interrupt |

## Verification
The bench targets the strobe orderings that a gating error would break. It sends a writeback strobe before any end-of-frame (a design that releases on any writeback would show status early). It sends end-of-frame and writeback in the same cycle (a design that does not wait for a later writeback would release at once). It sends an event in the very release cycle (a design that releases too much would show it one frame early). It also checks that a masked cause stays visible yet silent, and that an access error raises the line with the mask at zero. It also checks that set beats clear, and that the line stays high while any one source remains; a design with a pulsed or unregistered output, or one that lets clear win, would miss the expected cycle.

// File: rtl/usbirq_pkg.sv
package usbirq_pkg;

    localparam int TXN_CAUSES = 3;

    typedef enum logic [0:0] {
        GATE_OPEN  = 1'b0,
        GATE_ARMED = 1'b1
    } gate_state_t;

    typedef struct packed {
        logic shrt;
        logic err;
        logic ioc;
    } txn_ev_t;

    function automatic logic [TXN_CAUSES-1:0] ev_to_vec(input txn_ev_t ev);
        return {ev.shrt, ev.err, ev.ioc};
    endfunction

    function automatic txn_ev_t vec_to_ev(input logic [TXN_CAUSES-1:0] v);
        txn_ev_t r;
        r.ioc  = v[0];
        r.err  = v[1];
        r.shrt = v[2];
        return r;
    endfunction

    function automatic txn_ev_t ev_or(input txn_ev_t a, input txn_ev_t b);
        txn_ev_t r;
        r.ioc  = a.ioc  | b.ioc;
        r.err  = a.err  | b.err;
        r.shrt = a.shrt | b.shrt;
        return r;
    endfunction

endpackage

// File: rtl/usbirq_frame_gate.sv
module usbirq_frame_gate
    import usbirq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  txn_ev_t ev_i,
    input  logic    eof_i,
    input  logic    wb_done_i,
    output logic    release_o,
    output txn_ev_t release_ev_o
);

    gate_state_t state_q, state_d;
    txn_ev_t     pend_q, pend_d;
    logic        do_release;

    assign do_release = (state_q == GATE_ARMED) && wb_done_i;

    always_comb begin
        state_d = state_q;
        if (do_release) begin
            state_d = GATE_OPEN;
        end
        if (eof_i) begin
            state_d = GATE_ARMED;
        end
    end

    always_comb begin
        if (do_release) begin
            pend_d = ev_i;
        end else begin
            pend_d = ev_or(pend_q, ev_i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= GATE_OPEN;
            pend_q  <= '0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
        end
    end

    assign release_o    = do_release;
    assign release_ev_o = do_release ? pend_q : '0;

endmodule

// File: rtl/usbirq_status_regs.sv
module usbirq_status_regs #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic         clr_we_i,
    input  logic [W-1:0] clr_data_i,
    output logic [W-1:0] status_o
);

    logic [W-1:0] st_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic clr_bit;
        assign clr_bit = clr_we_i & clr_data_i[i];
        always_ff @(posedge clk) begin
            if (rst) begin
                st_q[i] <= 1'b0;
            end else if (set_i[i]) begin
                st_q[i] <= 1'b1;
            end else if (clr_bit) begin
                st_q[i] <= 1'b0;
            end
        end
    end

    assign status_o = st_q;

endmodule

// File: rtl/usbirq_irq_out.sv
module usbirq_irq_out
    import usbirq_pkg::*;
#(
    parameter int ACC_W = 1,
    localparam int ST_W = TXN_CAUSES + ACC_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ST_W-1:0]       status_i,
    input  logic [TXN_CAUSES-1:0] en_i,
    output logic                  irq_o
);

    logic [ST_W-1:0] mask;
    logic            irq_q;

    assign mask = {{ACC_W{1'b1}}, en_i};

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |(status_i & mask);
        end
    end

    assign irq_o = irq_q;

endmodule

// File: rtl/usbirq_agg.sv
module usbirq_agg
    import usbirq_pkg::*;
#(
    parameter int ACC_W = 1,
    localparam int ST_W = TXN_CAUSES + ACC_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [TXN_CAUSES-1:0] txn_ev_i,
    input  logic                  eof_i,
    input  logic                  wb_done_i,
    input  logic [ACC_W-1:0]      acc_err_i,
    input  logic [TXN_CAUSES-1:0] irq_en_i,
    input  logic                  clr_we_i,
    input  logic [ST_W-1:0]       clr_data_i,
    output logic [ST_W-1:0]       status_o,
    output logic                  irq_o
);

    txn_ev_t         rel_ev;
    logic            rel_pulse;
    logic [ST_W-1:0] set_vec;
    logic [ST_W-1:0] st;

    usbirq_frame_gate u_gate (
        .clk         (clk),
        .rst         (rst),
        .ev_i        (vec_to_ev(txn_ev_i)),
        .eof_i       (eof_i),
        .wb_done_i   (wb_done_i),
        .release_o   (rel_pulse),
        .release_ev_o(rel_ev)
    );

    assign set_vec = {acc_err_i, (rel_pulse ? ev_to_vec(rel_ev) : {TXN_CAUSES{1'b0}})};

    usbirq_status_regs #(.W(ST_W)) u_st (
        .clk       (clk),
        .rst       (rst),
        .set_i     (set_vec),
        .clr_we_i  (clr_we_i),
        .clr_data_i(clr_data_i),
        .status_o  (st)
    );

    usbirq_irq_out #(.ACC_W(ACC_W)) u_irq (
        .clk     (clk),
        .rst     (rst),
        .status_i(st),
        .en_i    (irq_en_i),
        .irq_o   (irq_o)
    );

    assign status_o = st;

endmodule

// File: rtl/usbirq_agg_chk.sv
module usbirq_agg_chk
    import usbirq_pkg::*;
#(
    parameter int ACC_W = 1,
    localparam int ST_W = TXN_CAUSES + ACC_W
) (
    input logic            clk,
    input logic            rst,
    input logic            wb_done_i,
    input logic [ACC_W-1:0] acc_err_i,
    input logic            clr_we_i,
    input logic [ST_W-1:0] clr_data_i,
    input logic [ST_W-1:0] status_o,
    input logic            irq_o
);

    for (genvar k = 0; k < TXN_CAUSES; k++) begin : g_txn
        AST_TXN_ONLY_ON_WB: assert property (@(posedge clk) disable iff (rst) $rose(status_o[k]) |-> $past(wb_done_i)); // R2
    end

    for (genvar j = 0; j < ACC_W; j++) begin : g_acc
        AST_ACC_SETS_UNMASKED: assert property (@(posedge clk) disable iff (rst) acc_err_i[j] |=> status_o[TXN_CAUSES+j]); // R5
        AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst) (clr_we_i && clr_data_i[TXN_CAUSES+j] && !acc_err_i[j]) |=> !status_o[TXN_CAUSES+j]); // R6
    end

    AST_QUIET_WHEN_EMPTY: assert property (@(posedge clk) disable iff (rst) (status_o == '0) |=> !irq_o); // R8
    AST_ACC_HOLDS_IRQ: assert property (@(posedge clk) disable iff (rst) (|status_o[ST_W-1:TXN_CAUSES]) |=> irq_o); // R9

endmodule

bind usbirq_agg usbirq_agg_chk #(.ACC_W(ACC_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wb_done_i (wb_done_i),
    .acc_err_i (acc_err_i),
    .clr_we_i  (clr_we_i),
    .clr_data_i(clr_data_i),
    .status_o  (status_o),
    .irq_o     (irq_o)
);

// File: tb/sim_usbirq_agg.sv
`timescale 1ns/1ps
module sim_usbirq_agg;

    localparam int ACC_W = 1;
    localparam int ST_W  = 3 + ACC_W;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [2:0]      txn_ev_i = '0;
    logic            eof_i = 1'b0;
    logic            wb_done_i = 1'b0;
    logic [ACC_W-1:0] acc_err_i = '0;
    logic [2:0]      irq_en_i = '0;
    logic            clr_we_i = 1'b0;
    logic [ST_W-1:0] clr_data_i = '0;
    logic [ST_W-1:0] status_o;
    logic            irq_o;

    usbirq_agg #(.ACC_W(ACC_W)) u0 (
        .clk(clk), .rst(rst), .txn_ev_i(txn_ev_i), .eof_i(eof_i),
        .wb_done_i(wb_done_i), .acc_err_i(acc_err_i), .irq_en_i(irq_en_i),
        .clr_we_i(clr_we_i), .clr_data_i(clr_data_i),
        .status_o(status_o), .irq_o(irq_o)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        logic [ST_W-1:0] st;
        logic            irq;
        string           tag;
    } exp_t;

    exp_t q[$];
    int   n_checks = 0;
    int   n_fails  = 0;
    bit   done     = 1'b0;

    // reference model state
    logic [2:0]      m_pend = '0;
    logic            m_arm  = 1'b0;
    logic [ST_W-1:0] m_st   = '0;
    logic            m_irq  = 1'b0;

    task automatic cyc(input bit r, input logic [2:0] ev, input bit eof, input bit wb,
                       input logic [ACC_W-1:0] acc, input logic [2:0] en,
                       input bit cwe, input logic [ST_W-1:0] cdat, input string tag);
        logic            rel;
        logic [ST_W-1:0] keep;
        logic [ST_W-1:0] n_st;
        logic            n_irq;
        @(negedge clk);
        rst = r; txn_ev_i = ev; eof_i = eof; wb_done_i = wb; acc_err_i = acc;
        irq_en_i = en; clr_we_i = cwe; clr_data_i = cdat;
        if (r) begin
            m_pend = '0; m_arm = 1'b0; m_st = '0; m_irq = 1'b0;
        end else begin
            rel   = wb && m_arm;
            keep  = cwe ? (m_st & ~cdat) : m_st;
            n_st  = keep | {acc, (rel ? m_pend : 3'b000)};
            n_irq = |(m_st & {{ACC_W{1'b1}}, en});
            m_pend = rel ? ev : (m_pend | ev);
            m_arm  = eof | (m_arm & ~rel);
            m_st   = n_st;
            m_irq  = n_irq;
        end
        q.push_back('{st: m_st, irq: m_irq, tag: tag});
    endtask

    task automatic idle(input logic [2:0] en, input string tag);
        cyc(0, 3'b000, 0, 0, '0, en, 0, '0, tag);
    endtask

    // monitor: compares one expected item after every rising edge
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_checks++;
            if (status_o !== e.st || irq_o !== e.irq) begin
                n_fails++;
                $display("FAIL %s: status=%b irq=%b expected status=%b irq=%b",
                         e.tag, status_o, irq_o, e.st, e.irq);
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        cyc(1, 3'b111, 1, 1, '1, 3'b111, 0, '0, "R1");
        cyc(1, 3'b000, 0, 0, '0, 3'b111, 0, '0, "R1");
        idle(3'b111, "R1");

        // R2 events held pending; R3 writeback without eof releases nothing
        cyc(0, 3'b001, 0, 0, '0, 3'b111, 0, '0, "R2");
        idle(3'b111, "R2");
        cyc(0, 3'b000, 0, 1, '0, 3'b111, 0, '0, "R3");
        idle(3'b111, "R3");
        // R3 eof and wb in the same cycle: not a release
        cyc(0, 3'b000, 1, 1, '0, 3'b111, 0, '0, "R3");
        idle(3'b111, "R3");
        cyc(0, 3'b000, 0, 1, '0, 3'b111, 0, '0, "R3");
        idle(3'b111, "R8");
        idle(3'b111, "R8");

        // R6 write zeros: no effect; write one: clears
        cyc(0, 3'b000, 0, 0, '0, 3'b111, 1, 4'b0000, "R6");
        cyc(0, 3'b000, 0, 0, '0, 3'b111, 1, 4'b0001, "R6");
        idle(3'b111, "R8");
        idle(3'b111, "R8");

        // R4 event in release cycle stays pending
        cyc(0, 3'b000, 1, 0, '0, 3'b111, 0, '0, "R4");
        cyc(0, 3'b010, 0, 1, '0, 3'b111, 0, '0, "R4");
        idle(3'b111, "R4");
        cyc(0, 3'b000, 1, 0, '0, 3'b111, 0, '0, "R4");
        cyc(0, 3'b000, 0, 1, '0, 3'b111, 0, '0, "R4");
        idle(3'b111, "R4");
        cyc(0, 3'b000, 0, 0, '0, 3'b111, 1, 4'b0010, "R6");
        idle(3'b111, "R8");
        idle(3'b111, "R8");

        // R9 masked cause visible but silent, then enabled
        cyc(0, 3'b100, 1, 0, '0, 3'b000, 0, '0, "R9");
        cyc(0, 3'b000, 0, 1, '0, 3'b000, 0, '0, "R9");
        idle(3'b000, "R9");
        idle(3'b000, "R9");
        idle(3'b100, "R8");
        idle(3'b100, "R8");
        cyc(0, 3'b000, 0, 0, '0, 3'b100, 1, 4'b0100, "R6");
        idle(3'b100, "R8");
        idle(3'b100, "R8");

        // R5 access error ignores mask
        cyc(0, 3'b000, 0, 0, 1'b1, 3'b000, 0, '0, "R5");
        idle(3'b000, "R5");
        idle(3'b000, "R5");
        // R7 set wins over clear
        cyc(0, 3'b000, 0, 0, 1'b1, 3'b000, 1, 4'b1000, "R7");
        idle(3'b000, "R7");

        // R9 two sources; irq holds until both cleared
        cyc(0, 3'b001, 1, 0, '0, 3'b001, 0, '0, "R9");
        cyc(0, 3'b000, 0, 1, '0, 3'b001, 0, '0, "R9");
        idle(3'b001, "R9");
        cyc(0, 3'b000, 0, 0, '0, 3'b001, 1, 4'b1000, "R9");
        idle(3'b001, "R9");
        idle(3'b001, "R9");
        cyc(0, 3'b000, 0, 0, '0, 3'b001, 1, 4'b0001, "R9");
        idle(3'b001, "R9");
        idle(3'b001, "R9");

        // R3 eof in release cycle arms the next release
        cyc(0, 3'b000, 1, 0, '0, 3'b111, 0, '0, "R3");
        cyc(0, 3'b010, 1, 1, '0, 3'b111, 0, '0, "R3");
        cyc(0, 3'b000, 0, 1, '0, 3'b111, 0, '0, "R3");
        idle(3'b111, "R3");
        idle(3'b111, "R3");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule